// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block raises one interrupt flag for each of the two ports of a shared memory and lowers it again. The memory is addressed with 14 bits. The two addresses at the top of the map act as mailboxes, one for each direction. The block watches the access signals of both ports every clock cycle. It never stores the message word itself, which stays in the memory beside it.

A port posts a message by writing its outgoing mailbox. On the next clock edge this raises the interrupt of the opposite port. The receiving port acknowledges by reading the same location, which drops its own interrupt on the next edge.

- The highest address (all ones) carries messages from the left port to the right port.
- The address one below it carries messages from the right port to the left port.

An access that the arbitration logic has blocked, shown by a per-port busy input, neither raises nor drops a flag. When a raise and a drop of the same flag arrive in one cycle, the raise wins, so no message is lost.

Top module: `mbox_irq_top`

## Requirements
- R1: While the asynchronous active-low reset is held, and on the first edge after its release, both interrupt outputs read 1, which means no interrupt.
- R2: A left write (enable 1, strobe 1, busy 0) to address 0x3FFF drives the right interrupt output to 0 after the next rising clock edge.
- R3: A right read (enable 1, output enable 1, strobe 0, busy 0) of address 0x3FFF drives the right interrupt output to 1 after the next rising clock edge.
- R4: A right write (enable 1, strobe 1, busy 0) to address 0x3FFE drives the left interrupt output to 0 after the next rising clock edge.
- R5: A left read (enable 1, output enable 1, strobe 0, busy 0) of address 0x3FFE drives the left interrupt output to 1 after the next rising clock edge.
- R6: Neither flag changes when a read has enable or output enable at 0, or when a write has enable at 0.
- R7: When the setting write and the clearing read of one flag fall in the same cycle, that flag is 0 after the edge.
- R8: An access whose port has busy at 1 neither sets nor clears any flag.
- R9: Neither flag changes after any of these accesses:
  - writes by a port to its incoming mailbox,
  - reads by a port of its outgoing mailbox,
  - accesses to any other address,
  - cycles with no access.
- R10: Each interrupt output is a plain registered 0/1 output, with no high-impedance state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lft_en | input | 1 | Left port access enable, 1 = active |
| lft_oe | input | 1 | Left port output enable, 1 = active |
| lft_wr | input | 1 | Left port strobe, 1 = write, 0 = read |
| lft_busy | input | 1 | Left port access blocked by arbitration |
| lft_addr | input | 14 | Left port address |
| rgt_en | input | 1 | Right port access enable, 1 = active |
| rgt_oe | input | 1 | Right port output enable, 1 = active |
| rgt_wr | input | 1 | Right port strobe, 1 = write, 0 = read |
| rgt_busy | input | 1 | Right port access blocked by arbitration |
| rgt_addr | input | 14 | Right port address |
| lft_irq_n | output | 1 | Left port interrupt, 0 = pending |
| rgt_irq_n | output | 1 | Right port interrupt, 0 = pending |

## Verification
The bench posts and acknowledges in each direction on its own. This separates the two flags and shows that each one is driven only by its own mailbox address.

Reads that lack output enable or enable, and writes that lack enable, check that partial strobe patterns are ignored. Writes to the incoming mailbox and reads of the outgoing one check that address and direction are both decoded.

A cycle in which the right port posts and the left port acknowledges at once shows that the raise wins. Accesses with busy held show that arbitration blocks both raises and drops.

A reset applied while both flags are pending proves that the reset is asynchronous.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

  // Direction of the read/write strobe
  typedef enum logic {
    STB_READ  = 1'b0,
    STB_WRITE = 1'b1
  } strobe_e;

  localparam int unsigned DEF_ADDR_W = 14;
  localparam int unsigned NUM_PORTS  = 2;

  // Mailbox address at a given distance below the top of an address space
  function automatic logic [DEF_ADDR_W-1:0] top_slot(input int unsigned below);
    logic [DEF_ADDR_W-1:0] top;
    top = '1;
    return top - DEF_ADDR_W'(below);
  endfunction

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
  import mbox_irq_pkg::*;
#(
  parameter int unsigned            ADDR_W   = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0]      OUT_SLOT = '1,
  parameter logic [ADDR_W-1:0]      IN_SLOT  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              oe,
  input  logic              wr,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              post,   // write to the outgoing mailbox
  output logic              fetch   // read of the incoming mailbox
);

  logic granted;
  logic hit_out;
  logic hit_in;
  logic is_write;

  always_comb begin
    granted  = en && !busy;
    is_write = (wr == STB_WRITE);
    hit_out  = (addr == OUT_SLOT);
    hit_in   = (addr == IN_SLOT);
    post     = granted && is_write && hit_out;
    fetch    = granted && !is_write && oe && hit_in;
  end

  // R8: a busy port produces no event
  p_busy_mutes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(post || fetch));

  // R6: a read without output enable never acknowledges
  p_oe_needed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !fetch);

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n
);

  logic irq_n_q;
  logic irq_n_d;
  logic upd_en;

  // Next state: raising wins over dropping
  always_comb begin
    upd_en  = set_i || clr_i;
    irq_n_d = irq_n_q;
    if (set_i) begin
      irq_n_d = 1'b0;
    end else if (clr_i) begin
      irq_n_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n_q <= 1'b1;
    end else if (upd_en) begin
      irq_n_q <= irq_n_d;
    end
  end

  assign irq_n = irq_n_q;

  // R7: a raise is never lost to a simultaneous drop
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !irq_n);

  // R3 / R5: a lone drop leaves the flag inactive
  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> irq_n);

  // R9: no event, no change
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i || clr_i) |=> $stable(irq_n));

endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top
  import mbox_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lft_en,
  input  logic              lft_oe,
  input  logic              lft_wr,
  input  logic              lft_busy,
  input  logic [ADDR_W-1:0] lft_addr,
  input  logic              rgt_en,
  input  logic              rgt_oe,
  input  logic              rgt_wr,
  input  logic              rgt_busy,
  input  logic [ADDR_W-1:0] rgt_addr,
  output logic              lft_irq_n,
  output logic              rgt_irq_n
);

  // Mailbox slots at the top of the map
  localparam logic [ADDR_W-1:0] SLOT_L2R = '1;
  localparam logic [ADDR_W-1:0] SLOT_R2L = ADDR_W'(SLOT_L2R - 1'b1);

  // Port 0 = left, port 1 = right
  logic              p_en   [NUM_PORTS];
  logic              p_oe   [NUM_PORTS];
  logic              p_wr   [NUM_PORTS];
  logic              p_busy [NUM_PORTS];
  logic [ADDR_W-1:0] p_addr [NUM_PORTS];
  logic              p_post [NUM_PORTS];
  logic              p_fetch[NUM_PORTS];
  logic              p_irq_n[NUM_PORTS];

  always_comb begin
    p_en[0]   = lft_en;
    p_oe[0]   = lft_oe;
    p_wr[0]   = lft_wr;
    p_busy[0] = lft_busy;
    p_addr[0] = lft_addr;
    p_en[1]   = rgt_en;
    p_oe[1]   = rgt_oe;
    p_wr[1]   = rgt_wr;
    p_busy[1] = rgt_busy;
    p_addr[1] = rgt_addr;
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    localparam logic [ADDR_W-1:0] OUT_S = (g == 0) ? SLOT_L2R : SLOT_R2L;
    localparam logic [ADDR_W-1:0] IN_S  = (g == 0) ? SLOT_R2L : SLOT_L2R;

    mbox_port_decode #(
      .ADDR_W   (ADDR_W),
      .OUT_SLOT (OUT_S),
      .IN_SLOT  (IN_S)
    ) i_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (p_en[g]),
      .oe    (p_oe[g]),
      .wr    (p_wr[g]),
      .busy  (p_busy[g]),
      .addr  (p_addr[g]),
      .post  (p_post[g]),
      .fetch (p_fetch[g])
    );

    // The flag of port g is raised by the other port, dropped by port g
    mbox_flag i_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (p_post[NUM_PORTS-1-g]),
      .clr_i (p_fetch[g]),
      .irq_n (p_irq_n[g])
    );
  end

  assign lft_irq_n = p_irq_n[0];
  assign rgt_irq_n = p_irq_n[1];

  // R2: a granted left post to the top slot raises the right flag
  p_left_post_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_en && lft_wr && !lft_busy && lft_addr == SLOT_L2R) |=> !rgt_irq_n);

  // R4: a granted right post raises the left flag
  p_right_post_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rgt_en && rgt_wr && !rgt_busy && rgt_addr == SLOT_R2L) |=> !lft_irq_n);

  // R8: a busy left port with a silent right port leaves both flags alone
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_busy && !rgt_en) |=> ($stable(lft_irq_n) && $stable(rgt_irq_n)));

  // R10: outputs are always a driven level
  p_driven_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({lft_irq_n, rgt_irq_n}));

endmodule

// File: tb/test_mbox_irq_top.sv
module test_mbox_irq_top;

  localparam int CLK_P = 10;
  localparam logic [13:0] A_L2R = 14'h3FFF;
  localparam logic [13:0] A_R2L = 14'h3FFE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lft_en, lft_oe, lft_wr, lft_busy;
  logic [13:0] lft_addr;
  logic        rgt_en, rgt_oe, rgt_wr, rgt_busy;
  logic [13:0] rgt_addr;
  logic        lft_irq_n, rgt_irq_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mbox_irq_top i_mbox_irq_top (
    .clk(clk), .rst_n(rst_n),
    .lft_en(lft_en), .lft_oe(lft_oe), .lft_wr(lft_wr), .lft_busy(lft_busy), .lft_addr(lft_addr),
    .rgt_en(rgt_en), .rgt_oe(rgt_oe), .rgt_wr(rgt_wr), .rgt_busy(rgt_busy), .rgt_addr(rgt_addr),
    .lft_irq_n(lft_irq_n), .rgt_irq_n(rgt_irq_n)
  );

  task automatic check(input string req, input logic exp_l, input logic exp_r);
    checks++;
    if (lft_irq_n !== exp_l || rgt_irq_n !== exp_r) begin
      errors++;
      $display("FAIL %s: lft_irq_n=%b rgt_irq_n=%b expected %b %b",
               req, lft_irq_n, rgt_irq_n, exp_l, exp_r);
    end
  endtask

  task automatic idle();
    lft_en = 0; lft_oe = 0; lft_wr = 0; lft_busy = 0; lft_addr = '0;
    rgt_en = 0; rgt_oe = 0; rgt_wr = 0; rgt_busy = 0; rgt_addr = '0;
  endtask

  // One cycle of stimulus on both ports; returns just after the edge
  task automatic cyc(input logic le, input logic lo, input logic lw, input logic lb,
                     input logic [13:0] la,
                     input logic re, input logic ro, input logic rw, input logic rb,
                     input logic [13:0] ra);
    @(negedge clk);
    lft_en = le; lft_oe = lo; lft_wr = lw; lft_busy = lb; lft_addr = la;
    rgt_en = re; rgt_oe = ro; rgt_wr = rw; rgt_busy = rb; rgt_addr = ra;
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic l_only(input logic e, input logic o, input logic w, input logic b,
                        input logic [13:0] a);
    cyc(e, o, w, b, a, 0, 0, 0, 0, '0);
  endtask

  task automatic r_only(input logic e, input logic o, input logic w, input logic b,
                        input logic [13:0] a);
    cyc(0, 0, 0, 0, '0, e, o, w, b, a);
  endtask

  task automatic t_reset();
    rst_n = 0;
    idle();
    #(CLK_P*2 + 1);
    check("R1 during reset", 1, 1);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    #1;
    check("R1 after release", 1, 1);
  endtask

  task automatic t_left_to_right();
    l_only(1, 0, 1, 0, A_L2R);
    check("R2 left post", 1, 0);
    r_only(1, 0, 0, 0, A_L2R);
    check("R6 read without oe", 1, 0);
    r_only(0, 1, 0, 0, A_L2R);
    check("R6 read without en", 1, 0);
    r_only(1, 1, 0, 0, A_L2R);
    check("R3 right ack", 1, 1);
  endtask

  task automatic t_right_to_left();
    r_only(1, 0, 1, 0, A_R2L);
    check("R4 right post", 0, 1);
    cyc(0, 0, 0, 0, '0, 0, 0, 0, 0, '0);
    check("R9 idle hold", 0, 1);
    l_only(1, 1, 0, 0, A_L2R);
    check("R9 left reads own outbox", 0, 1);
    l_only(1, 1, 0, 0, A_R2L);
    check("R5 left ack", 1, 1);
  endtask

  task automatic t_decode();
    l_only(1, 0, 1, 0, A_R2L);
    check("R9 left writes inbox", 1, 1);
    r_only(1, 0, 1, 0, A_L2R);
    check("R9 right writes inbox", 1, 1);
    l_only(1, 0, 1, 0, 14'h1FFF);
    check("R9 other address", 1, 1);
    l_only(0, 0, 1, 0, A_L2R);
    check("R6 write without en", 1, 1);
  endtask

  task automatic t_priority();
    // right posts to the left while the left acknowledges
    cyc(1, 1, 0, 0, A_R2L, 1, 0, 1, 0, A_R2L);
    check("R7 set wins from idle", 0, 1);
    cyc(1, 1, 0, 0, A_R2L, 1, 0, 1, 0, A_R2L);
    check("R7 set wins while pending", 0, 1);
    l_only(1, 1, 0, 0, A_R2L);
    check("R5 ack after priority", 1, 1);
  endtask

  task automatic t_busy();
    l_only(1, 0, 1, 1, A_L2R);
    check("R8 busy left post", 1, 1);
    l_only(1, 0, 1, 0, A_L2R);
    check("R2 post before busy read", 1, 0);
    r_only(1, 1, 0, 1, A_L2R);
    check("R8 busy right ack", 1, 0);
    r_only(1, 1, 0, 0, A_L2R);
    check("R3 ack after busy", 1, 1);
  endtask

  task automatic t_async_reset();
    cyc(1, 0, 1, 0, A_L2R, 1, 0, 1, 0, A_R2L);
    check("R2 R4 both pending", 0, 0);
    @(negedge clk);
    #2;
    rst_n = 0;
    #1;
    check("R1 asynchronous reset", 1, 1);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    #1;
    check("R1 after second release", 1, 1);
  endtask

  initial begin
    t_reset();
    t_left_to_right();
    t_right_to_left();
    t_decode();
    t_priority();
    t_busy();
    t_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule